// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block resolves one virtual address against a single group of a hashed page table held in an external synchronous memory. From the virtual address, a page-shift value and a table mask it forms the byte address of one group of eight slots. It then reads the slots one per cycle, lowest slot first. Each slot is a pair of 64-bit words. The first word carries the abbreviated virtual page number and status flags. The second word carries the real page number and the protection bits.

Each slot's first word is compared with a tag that the block builds from the address and a per-page-size clear mask. A slot is a hit only when its valid flag is set and its secondary flag agrees with the search mode. The scan stops at the first hit. The block then reports hit or miss, the slot number, and the translation fields of the matching slot.

A caller pulses `start` while `busy` is low, waits for the one-cycle `done` pulse, and reads the result. The result stays unchanged until the next accepted start. The mode input `sec_mode` selects the secondary group: the hash is inverted, and the block expects the secondary flag to be set.

Top module: `hpt_group_search`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `hit` and `mem_rd_en` are all low.
- R2: The first read address is (G << 7), where G = H AND `hash_mask`. H is the 39-bit value ((va >> 28) AND (2^39-1)) XOR ((va AND 0x0FFFFFFF) >> `page_shift`). After that, one read is issued per cycle and each address is 16 above the previous one. Reads start in the cycle after the start edge and continue until the matching slot has been read, or until all eight slots have been read. A hit in slot k therefore costs min(k+2, 8) reads.
- R3: When `sec_mode` is 1, the 39-bit H is inverted bitwise before the mask is applied.
- R4: The tag is ((va >> 23) AND NOT `avpn_clr`), taken as 57 bits. A slot's first word matches when its bits 63:7 equal the tag. Bits 6:2 of that word are ignored.
- R5: A slot whose first-word bit 0 (valid) is 0 never hits.
- R6: A slot hits only when its first-word bit 1 (secondary) equals `sec_mode`.
- R7: The lowest matching slot wins. When slot k hits, `done` is high during the cycle after the (k+2)-th clock edge following the start edge.
- R8: When no slot matches, `done` rises after the 9th edge following the start edge, with `hit` low. Exactly 8 reads are issued in that case.
- R9: On a hit, `real_pn` is bits 61:12 of the slot's second word, `prot_pp` is bits 1:0 and `no_exec` is bit 2.
- R10: A `start` that arrives while `busy` is high is ignored. It changes neither the search in progress nor its result.
- R11: `done` lasts one cycle. `hit`, `hit_slot`, `real_pn`, `prot_pp` and `no_exec` hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; accepted only while idle |
| va | input | 64 | Virtual address to translate |
| page_shift | input | 6 | Page shift used by the hash |
| avpn_clr | input | 57 | Per-page-size bits cleared from the tag |
| hash_mask | input | 39 | Mask applied to the group hash |
| sec_mode | input | 1 | Search the secondary group |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Last search found a matching slot |
| hit_slot | output | 3 | Slot number of the hit |
| real_pn | output | 50 | Real page number of the hit |
| prot_pp | output | 2 | Protection field of the hit |
| no_exec | output | 1 | No-execute bit of the hit |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Byte address of the slot being read |
| mem_v_word | input | 64 | First word of the slot, one cycle after the request |
| mem_r_word | input | 64 | Second word of the slot, one cycle after the request |

## Verification
The hardest case to produce from the ports is a group in which the slots ahead of the true match almost match. Such slots carry the right tag but have the valid flag cleared, carry the wrong secondary flag, or are a second copy of the match placed further along. The winning slot also has noise in its ignored low flag bits. Before each vector runs, the bench writes all eight slots of the group that it computes on its own, with the decoys built from the same tag, so only the intended slot can win. A separate test pulses `start` in the middle of a full-length scan, which is the only way to show that a second request cannot restart the search.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VA_W       = 64;
  localparam int SEG_SHIFT  = 28;
  localparam int HASH_W     = 39;
  localparam int PSHIFT_W   = 6;
  localparam int AVPN_SHIFT = 23;
  localparam int TAG_LSB    = 7;
  localparam int TAG_W      = VA_W - TAG_LSB;
  localparam int SLOT_N     = 8;
  localparam int SLOT_W     = $clog2(SLOT_N);
  localparam int ENTRY_LG   = 4;
  localparam int GROUP_LG   = SLOT_W + ENTRY_LG;
  localparam int VALID_BIT  = 0;
  localparam int SEC_BIT    = 1;
  localparam int RPN_LSB    = 12;
  localparam int RPN_W      = 50;
  localparam int PP_W       = 2;
  localparam int NX_BIT     = 2;

  typedef struct packed {
    logic [RPN_W-1:0] rpn;
    logic [PP_W-1:0]  pp;
    logic             nx;
  } xlat_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_t;
endpackage

// File: rtl/hpt_group_hash.sv
module hpt_group_hash
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 46
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [VA_W-1:0]     va,
  input  logic [PSHIFT_W-1:0] page_shift,
  input  logic [TAG_W-1:0]    avpn_clr,
  input  logic [HASH_W-1:0]   hash_mask,
  input  logic                sec_mode,
  output logic [ADDR_W-1:0]   base_addr,
  output logic [TAG_W-1:0]    tag_q,
  output logic                sec_q
);
  localparam int SEG_PAD = VA_W - SEG_SHIFT;
  localparam int GRP_PAD = VA_W - HASH_W;

  logic [HASH_W-1:0] seg_part;
  logic [HASH_W-1:0] page_part;
  logic [HASH_W-1:0] raw_hash;
  logic [HASH_W-1:0] sel_hash;
  logic [HASH_W-1:0] grp_idx;
  logic [VA_W-1:0]   in_seg;
  logic [TAG_W-1:0]  tag_next;

  // Fold the segment number against the page number inside the segment
  always_comb begin
    seg_part  = HASH_W'(va >> SEG_SHIFT);
    in_seg    = {{SEG_PAD{1'b0}}, va[SEG_SHIFT-1:0]};
    page_part = HASH_W'(in_seg >> page_shift);
    raw_hash  = seg_part ^ page_part;
    sel_hash  = sec_mode ? ~raw_hash : raw_hash;
    grp_idx   = sel_hash & hash_mask;
    base_addr = ADDR_W'({{GRP_PAD{1'b0}}, grp_idx} << GROUP_LG);
    tag_next  = TAG_W'(va >> AVPN_SHIFT) & ~avpn_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q <= '0;
      sec_q <= 1'b0;
    end else if (load) begin
      tag_q <= tag_next;
      sec_q <= sec_mode;
    end
  end
endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
  import hpt_pkg::*;
(
  input  logic [VA_W-1:0]  v_word,
  input  logic [TAG_W-1:0] tag,
  input  logic             sec,
  output logic             match
);
  logic tag_eq;
  logic flags_ok;

  always_comb begin
    tag_eq   = (v_word[VA_W-1:TAG_LSB] == tag);
    flags_ok = v_word[VALID_BIT] && (v_word[SEC_BIT] == sec);
    match    = tag_eq && flags_ok;
  end
endmodule

// File: rtl/hpt_scan_ctrl.sv
module hpt_scan_ctrl
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 46
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              match,
  input  logic [VA_W-1:0]   r_word,
  output logic              load,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [SLOT_W-1:0] hit_slot,
  output xlat_t             result,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int CNT_W = SLOT_W + 1;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << ENTRY_LG);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOT_N - 1);

  scan_st_t          state;
  logic [CNT_W-1:0]  issue_cnt;
  logic [SLOT_W-1:0] rd_slot;
  logic [SLOT_W-1:0] cmp_slot;
  logic              cmp_valid;
  logic              finish;
  xlat_t             decoded;

  always_comb begin
    load        = (state == ST_IDLE) && start;
    busy        = (state == ST_SCAN);
    finish      = busy && cmp_valid && (match || (cmp_slot == LAST_SLOT));
    decoded.rpn = r_word[RPN_LSB +: RPN_W];
    decoded.pp  = r_word[PP_W-1:0];
    decoded.nx  = r_word[NX_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      hit       <= 1'b0;
      hit_slot  <= '0;
      result    <= '0;
      rd_en     <= 1'b0;
      rd_addr   <= '0;
      rd_slot   <= '0;
      issue_cnt <= '0;
      cmp_valid <= 1'b0;
      cmp_slot  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          cmp_valid <= 1'b0;
          if (start) begin
            state     <= ST_SCAN;
            hit       <= 1'b0;
            hit_slot  <= '0;
            result    <= '0;
            rd_en     <= 1'b1;
            rd_addr   <= base_addr;
            rd_slot   <= '0;
            issue_cnt <= CNT_W'(1);
          end
        end
        default: begin
          cmp_valid <= rd_en && !finish;
          cmp_slot  <= rd_slot;
          if (finish) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            rd_en <= 1'b0;
            hit   <= match;
            if (match) begin
              hit_slot <= cmp_slot;
              result   <= decoded;
            end
          end else if (issue_cnt < CNT_W'(SLOT_N)) begin
            rd_en     <= 1'b1;
            rd_addr   <= rd_addr + STEP;
            rd_slot   <= issue_cnt[SLOT_W-1:0];
            issue_cnt <= issue_cnt + CNT_W'(1);
          end else begin
            rd_en <= 1'b0;
          end
        end
      endcase
    end
  end

  // R1: reset leaves the block idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && !rd_en && !hit));

  // R2: consecutive reads walk the group in 16-byte steps
  a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + STEP));

  // R8: no read is issued outside a search
  a_r8_reads_in_scan: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);

  // R7: every search ends with a completion pulse
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11: completion is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: idle results hold while no start arrives
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(hit) && $stable(hit_slot) && $stable(result)));
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
  import hpt_pkg::*;
#(
  parameter int ADDR_W = 46
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [VA_W-1:0]     va,
  input  logic [PSHIFT_W-1:0] page_shift,
  input  logic [TAG_W-1:0]    avpn_clr,
  input  logic [HASH_W-1:0]   hash_mask,
  input  logic                sec_mode,
  output logic                busy,
  output logic                done,
  output logic                hit,
  output logic [SLOT_W-1:0]   hit_slot,
  output logic [RPN_W-1:0]    real_pn,
  output logic [PP_W-1:0]     prot_pp,
  output logic                no_exec,
  output logic                mem_rd_en,
  output logic [ADDR_W-1:0]   mem_rd_addr,
  input  logic [VA_W-1:0]     mem_v_word,
  input  logic [VA_W-1:0]     mem_r_word
);
  logic              load;
  logic [ADDR_W-1:0] base_addr;
  logic [TAG_W-1:0]  tag_q;
  logic              sec_q;
  logic              match;
  xlat_t             result;

  hpt_group_hash #(.ADDR_W(ADDR_W)) u_hash (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .va        (va),
    .page_shift(page_shift),
    .avpn_clr  (avpn_clr),
    .hash_mask (hash_mask),
    .sec_mode  (sec_mode),
    .base_addr (base_addr),
    .tag_q     (tag_q),
    .sec_q     (sec_q)
  );

  hpt_entry_match u_match (
    .v_word(mem_v_word),
    .tag   (tag_q),
    .sec   (sec_q),
    .match (match)
  );

  hpt_scan_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .base_addr(base_addr),
    .match    (match),
    .r_word   (mem_r_word),
    .load     (load),
    .busy     (busy),
    .done     (done),
    .hit      (hit),
    .hit_slot (hit_slot),
    .result   (result),
    .rd_en    (mem_rd_en),
    .rd_addr  (mem_rd_addr)
  );

  assign real_pn = result.rpn;
  assign prot_pp = result.pp;
  assign no_exec = result.nx;

  // R10: a start during a search leaves the captured search key untouched
  a_r10_key_locked: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tag_q) && $stable(sec_q)));
endmodule

// File: tb/hpt_group_search_bench.sv
`timescale 1ns/1ps
module hpt_group_search_bench;
  localparam int ADDR_W = 46;
  localparam int NV = 10;
  localparam int MISS = 8;

  localparam logic [63:0] V_VA [NV] = '{
    64'h0000_0012_3456_7000, 64'h0000_00AB_CDEF_1000, 64'h0000_0040_0001_0000,
    64'h0000_0F00_0ABC_0000, 64'h0000_0033_1111_2000, 64'h0000_0777_7000_3000,
    64'h0000_0100_0FFF_5000, 64'h0000_0005_0000_0ABC, 64'h0000_0ACE_0246_8000,
    64'h0000_0DEF_0135_7000};
  localparam logic [5:0]  V_SH [NV] = '{6'd12, 6'd12, 6'd16, 6'd24, 6'd12, 6'd12, 6'd16, 6'd0, 6'd20, 6'd12};
  localparam logic [56:0] V_CLR [NV] = '{57'h0, 57'h0, 57'h1F, 57'h1, 57'h0, 57'h3, 57'h0, 57'h0, 57'hFF, 57'h0};
  localparam logic [38:0] V_MASK [NV] = '{39'h1F, 39'h0F, 39'h1F, 39'h1F, 39'h07, 39'h1F, 39'h1F, 39'h1F, 39'h0F, 39'h1F};
  localparam logic        V_SEC [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam int          V_SLOT [NV] = '{0, 3, 5, 7, 2, MISS, MISS, 6, 1, MISS};
  localparam int          V_DEC [NV] = '{0, 1, 2, 0, 3, 1, 2, 0, 3, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [63:0] va = '0;
  logic [5:0] page_shift = '0;
  logic [56:0] avpn_clr = '0;
  logic [38:0] hash_mask = '0;
  logic sec_mode = 1'b0;
  logic busy, done, hit, no_exec, mem_rd_en;
  logic [2:0] hit_slot;
  logic [49:0] real_pn;
  logic [1:0] prot_pp;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [63:0] mem_v_word, mem_r_word;

  logic [63:0] memv [256];
  logic [63:0] memr [256];

  int n_checks = 0;
  int n_fail = 0;
  int rd_cnt = 0;
  int step_err = 0;
  logic [63:0] first_addr = '0;
  logic [63:0] last_addr = '0;

  always #4 clk = ~clk;

  hpt_group_search #(.ADDR_W(ADDR_W)) u_hpt_group_search (
    .clk(clk), .rst(rst), .start(start), .va(va), .page_shift(page_shift),
    .avpn_clr(avpn_clr), .hash_mask(hash_mask), .sec_mode(sec_mode),
    .busy(busy), .done(done), .hit(hit), .hit_slot(hit_slot), .real_pn(real_pn),
    .prot_pp(prot_pp), .no_exec(no_exec), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_v_word(mem_v_word), .mem_r_word(mem_r_word));

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_v_word <= memv[mem_rd_addr[11:4]];
      mem_r_word <= memr[mem_rd_addr[11:4]];
    end
  end

  always @(negedge clk) begin
    if (mem_rd_en) begin
      if (rd_cnt == 0) first_addr = 64'(mem_rd_addr);
      else if (64'(mem_rd_addr) != last_addr + 64'd16) step_err = step_err + 1;
      last_addr = 64'(mem_rd_addr);
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] b_group(input int vi);
    logic [38:0] h;
    h = 39'((V_VA[vi] >> 28) & 64'h7F_FFFF_FFFF) ^ 39'((V_VA[vi] & 64'h0FFF_FFFF) >> V_SH[vi]);
    if (V_SEC[vi]) h = ~h;
    return h & V_MASK[vi];
  endfunction

  function automatic logic [56:0] b_tag(input int vi);
    return 57'(V_VA[vi] >> 23) & ~V_CLR[vi];
  endfunction

  function automatic logic [49:0] b_rpn(input int vi, input int s);
    return 50'(vi * 4099 + s * 131 + 17);
  endfunction

  function automatic logic [63:0] b_rword(input int vi, input int s);
    logic [1:0] pp;
    logic nx;
    pp = 2'(s + vi);
    nx = 1'(s) ^ 1'(vi);
    return {2'b11, b_rpn(vi, s), 9'h1F0, nx, pp};
  endfunction

  task automatic fill_group(input int vi);
    int g;
    logic [56:0] tg;
    logic sec;
    logic [63:0] v;
    g = int'(b_group(vi));
    tg = b_tag(vi);
    sec = V_SEC[vi];
    for (int s = 0; s < 8; s++) begin
      if (s == V_SLOT[vi]) v = {tg, 7'b0} | 64'h54 | {62'b0, sec, 1'b1};
      else if (s < V_SLOT[vi] && V_DEC[vi] == 1) v = {tg, 7'b0} | {62'b0, sec, 1'b0};
      else if (s < V_SLOT[vi] && V_DEC[vi] == 2) v = {tg, 7'b0} | {62'b0, ~sec, 1'b1};
      else if (s > V_SLOT[vi] && V_DEC[vi] == 3) v = {tg, 7'b0} | {62'b0, sec, 1'b1};
      else v = {tg ^ 57'(s + 1), 7'b0} | {62'b0, sec, 1'b1};
      memv[g * 8 + s] = v;
      memr[g * 8 + s] = b_rword(vi, s);
    end
  endtask

  // Runs one search; poke_at > 0 pulses a second start with other inputs at that cycle
  task automatic run_job(input int vi, input int poke_at, output int n_done);
    n_done = 0;
    rd_cnt = 0;
    step_err = 0;
    @(negedge clk);
    va = V_VA[vi]; page_shift = V_SH[vi]; avpn_clr = V_CLR[vi];
    hash_mask = V_MASK[vi]; sec_mode = V_SEC[vi]; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= 20; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (done && n_done == 0) n_done = n;
      if (n == poke_at) begin
        start = 1'b1; va = ~V_VA[vi]; sec_mode = ~V_SEC[vi]; hash_mask = 39'h1;
      end else begin
        start = 1'b0;
      end
      if (n_done != 0) break;
    end
  endtask

  task automatic check_vector(input int vi, input int n_done);
    int k;
    logic [63:0] g;
    k = V_SLOT[vi];
    g = 64'(b_group(vi)) << 7;
    chk(V_SEC[vi] ? "R3 secondary group address" : "R2 group address", first_addr, g);
    chk("R2 address steps", 64'(step_err), 64'd0);
    if (k == MISS) begin
      chk("R8 miss done timing", 64'(n_done), 64'd9);
      chk("R8 miss hit flag", 64'(hit), 64'd0);
      chk("R8 miss read count", 64'(rd_cnt), 64'd8);
    end else begin
      chk("R7 hit done timing", 64'(n_done), 64'(k + 2));
      chk("R4 R5 R6 hit flag", 64'(hit), 64'd1);
      chk("R7 lowest slot", 64'(hit_slot), 64'(k));
      chk("R2 read count", 64'(rd_cnt), 64'((k + 2 > 8) ? 8 : k + 2));
      chk("R9 real page number", 64'(real_pn), 64'(b_rpn(vi, k)));
      chk("R9 protection", 64'(prot_pp), 64'(b_rword(vi, k) & 64'h3));
      chk("R9 no execute", 64'(no_exec), 64'(b_rword(vi, k)[2]));
    end
  endtask

  initial begin
    #1000000;
    n_fail = n_fail + 1;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int nd;
    for (int i = 0; i < 256; i++) begin
      memv[i] = '0;
      memr[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
    chk("R1 reset hit", 64'(hit), 64'd0);
    chk("R1 reset read enable", 64'(mem_rd_en), 64'd0);

    for (int vi = 0; vi < NV; vi++) begin
      fill_group(vi);
      run_job(vi, 0, nd);
      check_vector(vi, nd);
      repeat (2) @(negedge clk);
    end

    // R10: second start mid-scan of a slot-7 hit is ignored
    fill_group(3);
    run_job(3, 3, nd);
    check_vector(3, nd);

    // R11: results hold and done stays low while idle inputs change
    fill_group(1);
    run_job(1, 0, nd);
    va = 64'hFFFF_0000_1234_5678; sec_mode = 1'b1; hash_mask = 39'h3;
    repeat (5) @(negedge clk);
    chk("R11 done pulse ended", 64'(done), 64'd0);
    chk("R11 hit held", 64'(hit), 64'd1);
    chk("R11 slot held", 64'(hit_slot), 64'd3);
    chk("R11 real page held", 64'(real_pn), 64'(b_rpn(1, 3)));
    chk("R11 no reads while idle", 64'(mem_rd_en), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule